// File: doc/BRIEF.md
# Fixed-Point Color Space Converter

This block converts one pixel per cycle from one color space to another. A pixel arrives on a valid/ready stream as a 40-bit word of four 10-bit components. Each of the three color components is first offset by a signed input bias and limited to an input window. The three results are then multiplied by a 3x3 matrix of signed 16.16 coefficients and summed at full precision. The sum is rounded to an integer, offset by a signed output bias and limited to an output window. The fourth component (alpha) is not converted and leaves with its own pixel.

Settings are written through a plain write port into a shadow set. A pixel flagged as the first of a frame (`s_sof`) takes a snapshot of the shadow set. That snapshot travels down the pipeline with the pixel and stays in use for every later pixel until the next flagged pixel. One frame therefore never mixes two settings, and the stream never has to drain.

Back-pressure rules: a word on the output is held stable while `m_valid` is high and `m_ready` is low. During such a stall the whole pipeline freezes and `s_ready` is low. `s_ready` is high whenever the output register is empty or `m_ready` is high. No pixel is dropped, duplicated or reordered.

Top module: `csc_core`

## Requirements
- R1: After reset, `m_valid` is low and `s_ready` is high. The active settings are the identity matrix (0x00010000 at addresses 0, 4 and 8, all other coefficients zero), all biases zero, and every clamp window [0, 1023]. Under these settings each output equals its input.
- R2: In a pixel word, channel k sits at bits [10k+9:10k], with green k=0, blue k=1, red k=2 and alpha k=3. Alpha leaves unchanged with its own pixel.
- R3: For each color channel c, the input value plus the signed input bias is clamped. The bias is at address 9+c and taken from write data bits [11:0] as a two's-complement value. The lower limit is at address 15+c and the upper limit at address 18+c, each from write data bits [9:0]. A value below the lower limit becomes the lower limit. Otherwise, a value above the upper limit becomes the upper limit.
- R4: Output channel i, before rounding, is the sum over j of coefficient[3i+j] times clamped input j. Coefficient[3i+j] is at address 3i+j and is a 32-bit signed value with 16 fraction bits. The sum is exact, with no overflow.
- R5: The exact sum is rounded by adding 2^15 and then shifting right arithmetically by 16, so ties move toward positive infinity. The signed output bias for channel i (address 12+i, write data bits [11:0]) is added after rounding.
- R6: The biased result is clamped as in R3, with the lower limit at address 21+i and the upper limit at address 24+i. Negative and very large results land on the limits.
- R7: Writes change only the shadow set. A pixel accepted with `s_sof` high, and every later pixel, uses the shadow contents as they stood at that pixel's acceptance. Writes made after that acceptance have no effect until the next `s_sof` pixel.
- R8: A pixel accepted at a clock edge appears on the output after the fourth rising edge, counting the accepting edge, when no stall occurs in between.
- R9: While `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` are held and `s_ready` is low. Every accepted pixel leaves exactly once, in order.
- R10: Writes to addresses 27 to 31 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 5 | Setting address |
| wr_data | input | 32 | Setting value |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_sof | input | 1 | Input pixel is the first of a frame |
| s_data | input | 40 | Input pixel word |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 40 | Output pixel word |

## Verification
The bench targets rounding ties of exactly one half, both positive and negative. A design that truncates, or that rounds toward zero, would be off by one on those pixels. Coefficients of the largest and smallest 16.16 magnitude push the sum to the edge of its width, where a narrow accumulator would wrap and land on the wrong clamp limit. Pixels are sent just below and above each clamp window under biases of both signs, so that any reversal of bias and clamp order shows up. The bench also writes new settings while a frame's pixels are still in flight and stalls the output at random. A design that swaps settings mid-frame would output pixels converted with the new values, and one that mishandles stalls would lose or repeat pixels.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W   = 10;
  localparam int NCH     = 3;
  localparam int COEF_W  = 32;
  localparam int FRAC_W  = 16;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 5;
  localparam int BIAS_W  = PIX_W + 2;
  localparam int NCOEF   = NCH * NCH;
  localparam int WORD_W  = (NCH + 1) * PIX_W;
  localparam int PRE_W   = BIAS_W + 1;
  localparam int PROD_W  = COEF_W + PIX_W + 1;
  localparam int SUM_W   = PROD_W + 2;
  localparam int RND_W   = SUM_W - FRAC_W;
  localparam int POST_W  = RND_W + 1;

  localparam int A_COEF      = 0;
  localparam int A_PRE_BIAS  = A_COEF + NCOEF;
  localparam int A_POST_BIAS = A_PRE_BIAS + NCH;
  localparam int A_PRE_LO    = A_POST_BIAS + NCH;
  localparam int A_PRE_HI    = A_PRE_LO + NCH;
  localparam int A_POST_LO   = A_PRE_HI + NCH;
  localparam int A_POST_HI   = A_POST_LO + NCH;

  typedef logic [PIX_W-1:0]          pix_t;
  typedef logic signed [COEF_W-1:0]  coef_t;
  typedef logic signed [BIAS_W-1:0]  bias_t;

  typedef struct packed {
    bias_t [NCH-1:0] bias;
    pix_t  [NCH-1:0] lo;
    pix_t  [NCH-1:0] hi;
  } stage_cfg_t;

  typedef struct packed {
    stage_cfg_t          pre;
    coef_t [NCOEF-1:0]   coef;
    stage_cfg_t          post;
  } csc_cfg_t;

  function automatic csc_cfg_t cfg_default();
    csc_cfg_t c;
    c = '0;
    for (int k = 0; k < NCOEF; k++)
      if (k % (NCH + 1) == 0) c.coef[k] = coef_t'(1) <<< FRAC_W;
    for (int ch = 0; ch < NCH; ch++) begin
      c.pre.hi[ch]  = '1;
      c.post.hi[ch] = '1;
    end
    return c;
  endfunction
endpackage

// File: rtl/csc_shadow_regs.sv
module csc_shadow_regs
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output csc_cfg_t          shadow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= cfg_default();
    end else if (wr_en) begin
      for (int k = 0; k < NCOEF; k++)
        if (wr_addr == ADDR_W'(A_COEF + k)) shadow.coef[k] <= wr_data;
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr == ADDR_W'(A_PRE_BIAS + c))  shadow.pre.bias[c]  <= wr_data[BIAS_W-1:0];
        if (wr_addr == ADDR_W'(A_POST_BIAS + c)) shadow.post.bias[c] <= wr_data[BIAS_W-1:0];
        if (wr_addr == ADDR_W'(A_PRE_LO + c))    shadow.pre.lo[c]    <= wr_data[PIX_W-1:0];
        if (wr_addr == ADDR_W'(A_PRE_HI + c))    shadow.pre.hi[c]    <= wr_data[PIX_W-1:0];
        if (wr_addr == ADDR_W'(A_POST_LO + c))   shadow.post.lo[c]   <= wr_data[PIX_W-1:0];
        if (wr_addr == ADDR_W'(A_POST_HI + c))   shadow.post.hi[c]   <= wr_data[PIX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/csc_chan_clamp.sv
module csc_chan_clamp
  import csc_pkg::*;
#(
  parameter int IN_W = PRE_W
) (
  input  logic signed [IN_W-1:0] val,
  input  pix_t                   lo,
  input  pix_t                   hi,
  output pix_t                   res
);
  localparam int PAD_W = IN_W - PIX_W;

  logic signed [IN_W-1:0] lo_x, hi_x;

  always_comb begin
    lo_x = $signed({{PAD_W{1'b0}}, lo});
    hi_x = $signed({{PAD_W{1'b0}}, hi});
    if (val < lo_x)      res = lo;
    else if (val > hi_x) res = hi;
    else                 res = val[PIX_W-1:0];
  end
endmodule

// File: rtl/csc_round_acc.sv
module csc_round_acc
  import csc_pkg::*;
(
  input  logic signed [NCH-1:0][PROD_W-1:0] prods,
  input  bias_t                             bias,
  output logic signed [POST_W-1:0]          res
);
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC_W - 1);

  logic signed [SUM_W-1:0] sum, rnd, shr;

  always_comb begin
    sum = '0;
    for (int j = 0; j < NCH; j++) sum = sum + SUM_W'($signed(prods[j]));
    rnd = sum + HALF;
    shr = rnd >>> FRAC_W;
    res = POST_W'(shr) + POST_W'($signed(bias));
  end
endmodule

// File: rtl/csc_core.sv
module csc_core
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_sof,
  input  logic [WORD_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data
);
  csc_cfg_t shadow, cfg_in, cfg1;
  stage_cfg_t post2;
  pix_t [NCH-1:0] lo3, hi3;

  logic adv, take;
  logic v1, v2, v3, v4;

  pix_t [NCH-1:0] pix_in, pre_clamped, p1, out_clamped, out4;
  pix_t a1, a2, a3, a4;
  logic signed [NCH-1:0][NCH-1:0][PROD_W-1:0] prod2;
  logic signed [NCH-1:0][POST_W-1:0] acc_next, acc3;

  csc_shadow_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .shadow(shadow)
  );

  assign adv     = !v4 || m_ready;
  assign take    = s_valid && adv;
  assign s_ready = adv;
  assign pix_in  = s_data[NCH*PIX_W-1:0];
  assign cfg_in  = s_sof ? shadow : cfg1;

  for (genvar c = 0; c < NCH; c++) begin : g_pre
    logic signed [PRE_W-1:0] biased;
    assign biased = PRE_W'($signed({1'b0, pix_in[c]})) + PRE_W'($signed(cfg_in.pre.bias[c]));
    csc_chan_clamp #(.IN_W(PRE_W)) u_clamp (
      .val(biased), .lo(cfg_in.pre.lo[c]), .hi(cfg_in.pre.hi[c]), .res(pre_clamped[c])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_row
    csc_round_acc u_acc (
      .prods(prod2[i]), .bias(post2.bias[i]), .res(acc_next[i])
    );
    csc_chan_clamp #(.IN_W(POST_W)) u_clamp (
      .val(acc3[i]), .lo(lo3[i]), .hi(hi3[i]), .res(out_clamped[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, v3, v4} <= '0;
      cfg1  <= cfg_default();
      post2 <= cfg_default().post;
      lo3   <= '0;
      hi3   <= '1;
      p1    <= '0;
      prod2 <= '0;
      acc3  <= '0;
      out4  <= '0;
      {a1, a2, a3, a4} <= '0;
    end else if (adv) begin
      v1 <= take;
      v2 <= v1;
      v3 <= v2;
      v4 <= v3;
      if (take) begin
        p1   <= pre_clamped;
        a1   <= s_data[NCH*PIX_W +: PIX_W];
        cfg1 <= cfg_in;
      end
      for (int i = 0; i < NCH; i++)
        for (int j = 0; j < NCH; j++)
          prod2[i][j] <= PROD_W'($signed(cfg1.coef[NCH*i+j])) * PROD_W'($signed({1'b0, p1[j]}));
      a2    <= a1;
      post2 <= cfg1.post;
      acc3  <= acc_next;
      lo3   <= post2.lo;
      hi3   <= post2.hi;
      a3    <= a2;
      out4  <= out_clamped;
      a4    <= a3;
    end
  end

  assign m_valid = v4;
  assign m_data  = {a4, out4};
endmodule

// File: rtl/csc_core_chk.sv
module csc_core_chk
  import csc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [WORD_W-1:0] m_data
);
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd0) |-> !m_valid) else $error("empty after reset"); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))) else $error("output not held"); // R9

  AST_BLOCKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready) else $error("input taken while stalled"); // R9

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready) else $error("not ready with empty output"); // R9

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 3'd4) && $past(s_valid && s_ready, 4) && $past(s_ready, 3)
      && $past(s_ready, 2) && $past(s_ready, 1)) |-> m_valid) else $error("latency"); // R8
endmodule

bind csc_core csc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
);

// File: tb/csc_core_test.sv
module csc_core_test;
  import csc_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, wr_en, s_valid, s_sof, m_ready;
  logic [ADDR_W-1:0] wr_addr;
  logic [REG_W-1:0]  wr_data;
  logic [WORD_W-1:0] s_data, m_data;
  logic s_ready, m_valid;

  csc_core uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  int nchk = 0, nerr = 0, nout = 0, nsent = 0;
  bit bp_mode = 1'b0;
  logic [WORD_W-1:0] exp_q[$];
  string tag_q[$];

  int sh_coef[9], sh_pb[3], sh_qb[3], sh_plo[3], sh_phi[3], sh_qlo[3], sh_qhi[3];
  int ac_coef[9], ac_pb[3], ac_qb[3], ac_plo[3], ac_phi[3], ac_qlo[3], ac_qhi[3];

  task automatic check(string tag, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic longint clampv(longint v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] ref_pixel(logic [WORD_W-1:0] p);
    longint pre[3];
    longint s, v;
    logic [WORD_W-1:0] r;
    for (int i = 0; i < 3; i++)
      pre[i] = clampv(longint'(p[10*i +: 10]) + ac_pb[i], ac_plo[i], ac_phi[i]);
    for (int i = 0; i < 3; i++) begin
      s = 0;
      for (int j = 0; j < 3; j++) s += longint'(ac_coef[3*i+j]) * pre[j];
      v = ((s + 64'sd32768) >>> 16) + ac_qb[i];
      r[10*i +: 10] = 10'(clampv(v, ac_qlo[i], ac_qhi[i]));
    end
    r[39:30] = p[39:30];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] px(int a, int r, int b, int g);
    return {10'(a), 10'(r), 10'(b), 10'(g)};
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 9; k++) sh_coef[k] = (k % 4 == 0) ? 65536 : 0;
    for (int c = 0; c < 3; c++) begin
      sh_pb[c] = 0; sh_qb[c] = 0; sh_plo[c] = 0; sh_qlo[c] = 0;
      sh_phi[c] = 1023; sh_qhi[c] = 1023;
    end
    ac_coef = sh_coef; ac_pb = sh_pb; ac_qb = sh_qb;
    ac_plo = sh_plo; ac_phi = sh_phi; ac_qlo = sh_qlo; ac_qhi = sh_qhi;
  endtask

  task automatic reg_write(int addr, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < 9)       sh_coef[addr]     = int'($signed(data));
    else if (addr < 12) sh_pb[addr - 9]   = int'($signed(data[11:0]));
    else if (addr < 15) sh_qb[addr - 12]  = int'($signed(data[11:0]));
    else if (addr < 18) sh_plo[addr - 15] = int'(data[9:0]);
    else if (addr < 21) sh_phi[addr - 18] = int'(data[9:0]);
    else if (addr < 24) sh_qlo[addr - 21] = int'(data[9:0]);
    else if (addr < 27) sh_qhi[addr - 24] = int'(data[9:0]);
  endtask

  task automatic send(logic [WORD_W-1:0] p, bit sof, string tag);
    bit rdy;
    @(negedge clk);
    s_valid = 1'b1; s_data = p; s_sof = sof;
    forever begin
      #1 rdy = s_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    if (sof) begin
      ac_coef = sh_coef; ac_pb = sh_pb; ac_qb = sh_qb;
      ac_plo = sh_plo; ac_phi = sh_phi; ac_qlo = sh_qlo; ac_qhi = sh_qhi;
    end
    exp_q.push_back(ref_pixel(p));
    tag_q.push_back(tag);
    nsent++;
    #1 s_valid = 1'b0; s_sof = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && m_valid && m_ready) begin
        nout++;
        if (exp_q.size() == 0) begin
          check("R9", "unexpected output", longint'(m_data), 0);
        end else begin
          automatic logic [WORD_W-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, "pixel", longint'(m_data), longint'(e));
        end
      end
    end
  end

  // downstream ready driver
  initial begin
    m_ready = 1'b1;
    forever begin
      @(posedge clk);
      #2 m_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    s_valid = 1'b0; s_sof = 1'b0; s_data = '0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "m_valid after reset", longint'(m_valid), 0);
    check("R1", "s_ready after reset", longint'(s_ready), 1);

    // R1: default settings pass pixels unchanged
    send(px(0, 0, 0, 0), 0, "R1");
    send(px(1023, 1023, 1023, 1023), 0, "R1");
    send(px(17, 300, 600, 900), 0, "R1");
    // R2: channel placement and alpha
    send(px(10'h2AA, 700, 5, 1023), 0, "R2");
    send(px(10'h155, 1, 512, 2), 0, "R2");
    drain();

    // R8: latency with an empty pipe
    begin
      int n = 0;
      send(px(3, 4, 5, 6), 0, "R8");
      forever begin
        @(negedge clk); #1; n++;
        if (m_valid || n > 10) break;
      end
      check("R8", "latency cycles", n, 4);
    end
    drain();

    // R3: input bias and clamp
    reg_write(9, -100); reg_write(10, 50); reg_write(11, 0);
    reg_write(15, 20);  reg_write(16, 100); reg_write(17, 200);
    reg_write(18, 900); reg_write(19, 1000); reg_write(20, 800);
    send(px(1, 150, 60, 30), 1, "R3");
    send(px(2, 1023, 1023, 1023), 0, "R3");
    send(px(3, 500, 980, 500), 0, "R3");
    send(px(4, 800, 49, 121), 0, "R3");
    send(px(5, 199, 51, 119), 0, "R3");
    drain();

    // R4: general matrix
    reg_write(0, 32'h0000_8000); reg_write(1, -16384); reg_write(2, 73728);
    reg_write(3, -98304); reg_write(4, 131072); reg_write(5, 21845);
    reg_write(6, 10000); reg_write(7, 20000); reg_write(8, 30000);
    send(px(6, 400, 300, 200), 1, "R4");
    send(px(7, 800, 150, 900), 0, "R4");
    send(px(8, 250, 700, 333), 0, "R4");
    drain();

    // R6: output bias, output clamp, extreme coefficients
    reg_write(12, 12); reg_write(13, -40); reg_write(14, 5);
    reg_write(21, 16); reg_write(22, 0); reg_write(23, 32);
    reg_write(24, 1000); reg_write(25, 1023); reg_write(26, 990);
    reg_write(6, 32'h7FFF_0000); reg_write(7, 32'h8000_0000); reg_write(8, 65536);
    send(px(9, 500, 200, 700), 1, "R6");
    send(px(10, 100, 999, 100), 0, "R6");
    send(px(11, 800, 30, 30), 0, "R6");
    send(px(12, 1023, 100, 1023), 0, "R6");
    drain();

    // R5: rounding ties
    for (int c = 0; c < 3; c++) begin
      reg_write(9 + c, 0); reg_write(15 + c, 0); reg_write(18 + c, 1023);
      reg_write(21 + c, 0); reg_write(24 + c, 1023);
    end
    reg_write(12, 0); reg_write(13, 10); reg_write(14, 0);
    reg_write(0, 32'h0000_8000); reg_write(1, 0); reg_write(2, 0);
    reg_write(3, 32'hFFFF_8000); reg_write(4, 0); reg_write(5, 0);
    reg_write(6, 32'h0000_8000); reg_write(7, 32'h0000_8000); reg_write(8, 32'h0000_8000);
    send(px(13, 0, 0, 1), 1, "R5");
    send(px(14, 0, 0, 3), 0, "R5");
    send(px(15, 1, 0, 5), 0, "R5");
    send(px(16, 1, 1, 1), 0, "R5");
    send(px(17, 2, 2, 7), 0, "R5");
    drain();

    // R7: shadow settings switch only at frame start
    reg_write(0, 131072);
    send(px(18, 9, 9, 100), 0, "R7");
    send(px(19, 9, 9, 100), 1, "R7");
    reg_write(0, 196608);
    send(px(20, 9, 9, 100), 0, "R7");
    send(px(21, 9, 9, 200), 0, "R7");
    drain();

    // R10: unused addresses
    for (int a = 27; a < 32; a++) reg_write(a, 32'hFFFF_FFFF);
    send(px(22, 40, 50, 60), 1, "R10");
    send(px(23, 1000, 2, 511), 0, "R10");
    drain();

    // R9: random back-pressure with mid-stream frame starts
    bp_mode = 1'b1;
    begin
      int sent0 = nsent, out0 = nout;
      for (int k = 0; k < 48; k++) begin
        if (k == 20) reg_write(4, 98304);
        send(px(k * 7, (k * 37) % 1024, (k * 101) % 1024, (k * 53) % 1024), (k % 16) == 0, "R9");
      end
      drain();
      bp_mode = 1'b0;
      repeat (4) @(negedge clk);
      check("R9", "pixels out vs in", nout - out0, nsent - sent0);
    end
    check("R9", "scoreboard empty", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule